// File: doc/BRIEF.md
# Posted-Write Real-Time Clock Register Block

This block keeps time as a 64-bit count: an upper 32-bit seconds word and a lower 32-bit fraction word. It also holds a 64-bit alarm value, a run control, a status word and an interrupt mask, all on a small 32-bit register bus. Each rising-edge cycle in which `tick_en` is high stands in for one cycle of the slow timekeeping clock. While counting runs, each such cycle adds one to the 64-bit count.

Register writes are posted and do not take effect at once. An accepted write holds the port busy for a fixed number of ticks. When that number is reached, the write lands, the port is free again and a completion flag rises. A write that arrives while the port is busy is discarded and an error flag is set. Software clears the error flag only by sending another write through the same path. After reset the block sits in a non-valid state, and the count stays frozen until the seconds word has been written once.

Top module: `rtc_regblock`

## Requirements
- R1: After reset the status word (word 5) reads 0x202: ready-for-next in bit 9 and non-valid in bit 1. The alarm seconds word (word 2) reads 0xFFFFFFFF. Both count words (word 0 seconds, word 1 fraction) read 0.
- R2: A write accepted while the port is idle sets busy (status bit 10) and clears ready-for-next (bit 9). After exactly WR_LAT high `tick_en` cycles the write lands, busy clears and write-complete (bit 8) sets, all in that same cycle.
- R3: A bus write that arrives while busy is set is discarded: its target keeps its value and write-error (status bit 7) becomes set.
- R4: Write-error is cleared only when a status write carrying bit 7 lands. A landed status write sets write-complete unless that write carries bit 8, in which case it clears write-complete.
- R5: Status bits 8, 7 and 4 are write-one-to-clear. Non-valid (bit 1) clears only when a landed status write has bits 1 and 0 both set; bit 1 alone leaves it set.
- R6: The count does not advance until the seconds word has been written once since reset, even with run enabled and the block valid.
- R7: The count advances by one per `tick_en` cycle, with the fraction carrying into the seconds, only while control bit 3 (word 4) is set and non-valid is clear.
- R8: When a write to a count word lands on a tick, the loaded value replaces that tick's increment.
- R9: The alarm flag (status bit 4) sets in the cycle the count steps onto the 64-bit alarm value {word 2, word 3}, unless word 2 is 0xFFFFFFFF. It stays set until cleared, and a set in the same cycle as a landing clear wins.
- R10: `irq` is a registered copy, one cycle late, of the OR of status bits 9, 8, 7 and 4, each gated by the interrupt-mask bit (word 6) with the same position.
- R11: `bus_rdata` shows, one cycle late, the word addressed by `bus_addr`. Control reads back only bit 3, and address 7 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | One slow-clock tick per high cycle |
| bus_we | input | 1 | Write strobe |
| bus_addr | input | 3 | Word index for writes and reads |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq | output | 1 | Registered interrupt request |

## Verification
The sharpest collision is a posted status write that clears the alarm flag and lands on the same tick on which the count steps onto the alarm value. The bench sets up the stopped count four steps below the alarm and enables counting. It then posts the clear straight away, so that the fourth tick of the write's latency is also the matching step. The flag must then read as still set. A second collision comes from a count-word write that lands on a tick; the bench reads the word before the next tick and expects the loaded value, not the loaded value plus one. A behavioural model predicts the read data and the interrupt in every cycle.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int REG_W  = 32;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    W_SEC   = 3'd0,
    W_FRAC  = 3'd1,
    W_ASEC  = 3'd2,
    W_AFRAC = 3'd3,
    W_CTRL  = 3'd4,
    W_STAT  = 3'd5,
    W_IMASK = 3'd6
  } rtc_word_e;

  localparam int B_BUSY = 10;
  localparam int B_NEXT = 9;
  localparam int B_DONE = 8;
  localparam int B_ERR  = 7;
  localparam int B_ALRM = 4;
  localparam int B_RUN  = 3;
  localparam int B_INV  = 1;
  localparam int B_VIOL = 0;
endpackage

// File: rtl/rtc_write_port.sv
module rtc_write_port #(
  parameter int DW  = 32,
  parameter int AW  = 3,
  parameter int LAT = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick_en,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic          busy,
  output logic          commit,
  output logic          reject,
  output logic [AW-1:0] post_addr,
  output logic [DW-1:0] post_data
);
  localparam int CW = $clog2(LAT + 1);

  logic [CW-1:0] left;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      left      <= '0;
      post_addr <= '0;
      post_data <= '0;
    end else if (busy) begin
      if (tick_en) begin
        left <= left - 1'b1;
        if (left == CW'(1)) busy <= 1'b0;
      end
    end else if (bus_we) begin
      busy      <= 1'b1;
      left      <= CW'(LAT);
      post_addr <= bus_addr;
      post_data <= bus_wdata;
    end
  end

  assign commit = busy && tick_en && (left == CW'(1));
  assign reject = bus_we && busy;
endmodule

// File: rtl/rtc_timebase.sv
module rtc_timebase #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick_en,
  input  logic         run_ok,
  input  logic         ld_hi,
  input  logic         ld_lo,
  input  logic [W-1:0] ld_val,
  output logic [W-1:0] hi,
  output logic [W-1:0] lo,
  output logic         seeded,
  output logic         step
);
  assign step = tick_en && run_ok && seeded && !ld_hi && !ld_lo;

  always_ff @(posedge clk) begin
    if (rst) begin
      hi     <= '0;
      lo     <= '0;
      seeded <= 1'b0;
    end else begin
      if (ld_hi) begin
        hi     <= ld_val;
        seeded <= 1'b1;
      end
      if (ld_lo) lo <= ld_val;
      if (step) {hi, lo} <= {hi, lo} + 1'b1;
    end
  end
endmodule

// File: rtl/rtc_regblock.sv
module rtc_regblock
  import rtc_pkg::*;
#(
  parameter int WR_LAT = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  output logic              irq
);
  localparam logic [REG_W-1:0] NO_ALARM = '1;

  logic              busy, commit, reject;
  logic [ADDR_W-1:0] p_addr;
  logic [REG_W-1:0]  p_data;
  logic [REG_W-1:0]  cnt_hi, cnt_lo;
  logic              seeded, step;
  logic [REG_W-1:0]  al_hi, al_lo;
  logic              run_bit;
  logic [3:0]        imask;
  logic              f_done, f_err, f_alrm, f_inv;
  logic              stat_wr, alarm_hit, run_ok;
  logic [3:0]        irq_vec;
  logic [REG_W-1:0]  stat_word, rd_next;

  rtc_write_port #(.DW(REG_W), .AW(ADDR_W), .LAT(WR_LAT)) u_wport (
    .clk(clk), .rst(rst), .tick_en(tick_en),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .busy(busy), .commit(commit), .reject(reject),
    .post_addr(p_addr), .post_data(p_data)
  );

  assign run_ok = run_bit && !f_inv;

  rtc_timebase #(.W(REG_W)) u_time (
    .clk(clk), .rst(rst), .tick_en(tick_en), .run_ok(run_ok),
    .ld_hi(commit && (p_addr == W_SEC)),
    .ld_lo(commit && (p_addr == W_FRAC)),
    .ld_val(p_data),
    .hi(cnt_hi), .lo(cnt_lo), .seeded(seeded), .step(step)
  );

  assign stat_wr   = commit && (p_addr == W_STAT);
  assign alarm_hit = step && (al_hi != NO_ALARM) &&
                     (({cnt_hi, cnt_lo} + 1'b1) == {al_hi, al_lo});

  always_ff @(posedge clk) begin
    if (rst) begin
      al_hi   <= NO_ALARM;
      al_lo   <= '0;
      run_bit <= 1'b0;
      imask   <= '0;
    end else if (commit) begin
      unique case (p_addr)
        W_ASEC:  al_hi   <= p_data;
        W_AFRAC: al_lo   <= p_data;
        W_CTRL:  run_bit <= p_data[B_RUN];
        W_IMASK: imask   <= {p_data[B_NEXT], p_data[B_DONE], p_data[B_ERR], p_data[B_ALRM]};
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      f_done <= 1'b0;
      f_err  <= 1'b0;
      f_alrm <= 1'b0;
      f_inv  <= 1'b1;
    end else begin
      if (commit) f_done <= !(stat_wr && p_data[B_DONE]);
      f_err  <= (f_err && !(stat_wr && p_data[B_ERR])) || reject;
      f_alrm <= (f_alrm && !(stat_wr && p_data[B_ALRM])) || alarm_hit;
      if (stat_wr && p_data[B_INV] && p_data[B_VIOL]) f_inv <= 1'b0;
    end
  end

  always_comb begin
    stat_word         = '0;
    stat_word[B_BUSY] = busy;
    stat_word[B_NEXT] = !busy;
    stat_word[B_DONE] = f_done;
    stat_word[B_ERR]  = f_err;
    stat_word[B_ALRM] = f_alrm;
    stat_word[B_INV]  = f_inv;
  end

  always_comb begin
    rd_next = '0;
    unique case (bus_addr)
      W_SEC:   rd_next = cnt_hi;
      W_FRAC:  rd_next = cnt_lo;
      W_ASEC:  rd_next = al_hi;
      W_AFRAC: rd_next = al_lo;
      W_CTRL:  rd_next[B_RUN] = run_bit;
      W_STAT:  rd_next = stat_word;
      W_IMASK: begin
        rd_next[B_NEXT] = imask[3];
        rd_next[B_DONE] = imask[2];
        rd_next[B_ERR]  = imask[1];
        rd_next[B_ALRM] = imask[0];
      end
      default: rd_next = '0;
    endcase
  end

  assign irq_vec = {!busy, f_done, f_err, f_alrm} & imask;

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      irq       <= 1'b0;
    end else begin
      bus_rdata <= rd_next;
      irq       <= |irq_vec;
    end
  end
endmodule

// File: rtl/rtc_regblock_chk.sv
module rtc_regblock_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic         tick_en,
  input logic         bus_we,
  input logic         busy,
  input logic         commit,
  input logic         seeded,
  input logic [W-1:0] cnt_hi,
  input logic [W-1:0] cnt_lo,
  input logic         f_alrm,
  input logic         f_err,
  input logic [3:0]   irq_vec,
  input logic         irq
);
  // R2: the posted write cannot finish without a tick
  a_r2_busy_holds_without_tick: assert property (@(posedge clk) disable iff (rst)
    busy && !tick_en |=> busy);

  // R3: a write during busy raises the error flag
  a_r3_reject_sets_error: assert property (@(posedge clk) disable iff (rst)
    bus_we && busy |=> f_err);

  // R6: no movement of the count before the first seconds load
  a_r6_frozen_until_seeded: assert property (@(posedge clk) disable iff (rst)
    !seeded && !commit |=> $stable(cnt_hi) && $stable(cnt_lo));

  // R9: the alarm flag only drops through a landed write
  a_r9_alarm_sticky: assert property (@(posedge clk) disable iff (rst)
    f_alrm && !commit |=> f_alrm);

  // R10: no enabled source means no request in the next cycle
  a_r10_irq_quiet: assert property (@(posedge clk) disable iff (rst)
    !(|irq_vec) |=> !irq);
endmodule

bind rtc_regblock rtc_regblock_chk #(.W(rtc_pkg::REG_W)) u_chk (
  .clk(clk), .rst(rst), .tick_en(tick_en), .bus_we(bus_we),
  .busy(busy), .commit(commit), .seeded(seeded),
  .cnt_hi(cnt_hi), .cnt_lo(cnt_lo), .f_alrm(f_alrm), .f_err(f_err),
  .irq_vec(irq_vec), .irq(irq)
);

// File: tb/test_rtc_regblock.sv
module test_rtc_regblock;
  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 4;
  localparam int LAT        = 4;
  localparam int WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic        rst;
  logic        tick_en = 1'b0;
  logic        bus_we;
  logic [2:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        irq;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc   = 0;
  int tcnt  = 0;
  string cur_req = "R1";

  rtc_regblock #(.WR_LAT(LAT)) i_rtc_regblock (
    .clk(clk), .rst(rst), .tick_en(tick_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    tick_en = (tcnt == TICK_DIV - 1);
    tcnt    = (tcnt == TICK_DIV - 1) ? 0 : tcnt + 1;
  end

  // ---------------- behavioural reference ----------------
  logic        m_busy;
  int          m_left;
  logic [2:0]  m_pa;
  logic [31:0] m_pd;
  logic [63:0] m_cnt;
  logic        m_started, m_tce;
  logic [31:0] m_asec, m_afrac;
  logic [3:0]  m_ie;
  logic        m_wcf, m_wef, m_caf, m_nvf;
  logic [31:0] m_rdata;
  logic        m_irq;
  logic        e_cm, e_rj, e_run, e_ldh, e_ldl, e_stp, e_hit, e_sw;
  logic [31:0] e_rd;
  logic        e_irq;

  function automatic logic [31:0] ref_word(input logic [2:0] a);
    logic [31:0] w = 32'h0;
    case (a)
      3'd0: w = m_cnt[63:32];
      3'd1: w = m_cnt[31:0];
      3'd2: w = m_asec;
      3'd3: w = m_afrac;
      3'd4: w[3] = m_tce;
      3'd5: begin
        w[10] = m_busy; w[9] = !m_busy; w[8] = m_wcf;
        w[7] = m_wef; w[4] = m_caf; w[1] = m_nvf;
      end
      3'd6: begin w[9] = m_ie[3]; w[8] = m_ie[2]; w[7] = m_ie[1]; w[4] = m_ie[0]; end
      default: w = 32'h0;
    endcase
    return w;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_busy = 0; m_left = 0; m_pa = 0; m_pd = 0; m_cnt = 0; m_started = 0;
      m_tce = 0; m_asec = 32'hFFFF_FFFF; m_afrac = 0; m_ie = 0;
      m_wcf = 0; m_wef = 0; m_caf = 0; m_nvf = 1; m_rdata = 0; m_irq = 0;
    end else begin
      e_rd  = ref_word(bus_addr);
      e_irq = (!m_busy && m_ie[3]) || (m_wcf && m_ie[2]) || (m_wef && m_ie[1]) || (m_caf && m_ie[0]);
      e_cm  = m_busy && tick_en && (m_left == 1);
      e_rj  = bus_we && m_busy;
      e_run = m_tce && m_started && !m_nvf;
      e_ldh = e_cm && (m_pa == 3'd0);
      e_ldl = e_cm && (m_pa == 3'd1);
      e_stp = tick_en && e_run && !e_ldh && !e_ldl;
      e_hit = e_stp && (m_cnt + 64'd1 == {m_asec, m_afrac}) && (m_asec != 32'hFFFF_FFFF);
      e_sw  = e_cm && (m_pa == 3'd5);
      if (e_cm) m_wcf = !(e_sw && m_pd[8]);
      if (e_sw && m_pd[7]) m_wef = 0;
      if (e_rj) m_wef = 1;
      if (e_sw && m_pd[4]) m_caf = 0;
      if (e_hit) m_caf = 1;
      if (e_sw && m_pd[1] && m_pd[0]) m_nvf = 0;
      if (e_ldh) begin m_cnt[63:32] = m_pd; m_started = 1; end
      if (e_ldl) m_cnt[31:0] = m_pd;
      if (e_stp) m_cnt = m_cnt + 64'd1;
      if (e_cm) begin
        case (m_pa)
          3'd2: m_asec  = m_pd;
          3'd3: m_afrac = m_pd;
          3'd4: m_tce   = m_pd[3];
          3'd6: m_ie    = {m_pd[9], m_pd[8], m_pd[7], m_pd[4]};
          default: ;
        endcase
      end
      if (m_busy) begin
        if (tick_en) begin
          m_left = m_left - 1;
          if (m_left == 0) m_busy = 0;
        end
      end else if (bus_we) begin
        m_busy = 1; m_left = LAT; m_pa = bus_addr; m_pd = bus_wdata;
      end
      m_rdata = e_rd;
      m_irq   = e_irq;
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    cyc = cyc + 1;
    if (!rst) begin
      n_cmp = n_cmp + 2;
      if (bus_rdata !== m_rdata) begin
        n_bad = n_bad + 1;
        $display("FAIL %s rdata actual=%h expected=%h", cur_req, bus_rdata, m_rdata);
      end
      if (irq !== m_irq) begin
        n_bad = n_bad + 1;
        $display("FAIL %s irq actual=%0b expected=%0b", cur_req, irq, m_irq);
      end
    end
    if (cyc > WATCHDOG) begin
      n_bad = n_bad + 1;
      $display("FAIL watchdog actual=%0d expected<=%0d", cyc, WATCHDOG);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_cmp = n_cmp + 1;
    if (got !== exp) begin
      n_bad = n_bad + 1;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 0;
  endtask

  task automatic idle();
    while (m_busy) @(negedge clk);
  endtask

  task automatic wr_wait(input logic [2:0] a, input logic [31:0] d);
    wr(a, d);
    idle();
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    bus_addr = a;
    @(negedge clk);
    v = bus_rdata;
  endtask

  task automatic ticks(input int n);
    repeat (n * TICK_DIV) @(negedge clk);
  endtask

  logic [31:0] v, v1;

  initial begin
    rst = 1; bus_we = 0; bus_addr = 0; bus_wdata = 0;
    repeat (3) @(negedge clk);
    rst = 0;

    cur_req = "R1";
    rd(3'd5, v); chk("R1 status", v, 32'h202);
    rd(3'd2, v); chk("R1 alarm sec", v, 32'hFFFF_FFFF);
    rd(3'd0, v); chk("R1 seconds", v, 32'h0);
    cur_req = "R11";
    rd(3'd7, v); chk("R11 unused word", v, 32'h0);

    cur_req = "R2";
    wr(3'd4, 32'hFFFF_FFFF);
    rd(3'd5, v); chk("R2 busy", v, 32'h402);
    idle();
    rd(3'd5, v); chk("R2 complete", v, 32'h302);
    cur_req = "R11";
    rd(3'd4, v); chk("R11 control bit 3 only", v, 32'h8);

    cur_req = "R5";
    wr_wait(3'd5, 32'h2);
    rd(3'd5, v); chk("R5 bit1 alone keeps non-valid", v, 32'h302);
    cur_req = "R6";
    ticks(3);
    rd(3'd1, v); chk("R6 frozen fraction", v, 32'h0);
    cur_req = "R5";
    wr_wait(3'd5, 32'h3);
    rd(3'd5, v); chk("R5 valid restored", v, 32'h300);
    cur_req = "R6";
    ticks(3);
    rd(3'd1, v); chk("R6 frozen while valid and enabled", v, 32'h0);
    wr_wait(3'd1, 32'hFFFF_FFFD);
    ticks(3);
    rd(3'd1, v); chk("R6 still frozen after fraction load", v, 32'hFFFF_FFFD);

    cur_req = "R7";
    wr_wait(3'd0, 32'h5);
    ticks(5);
    rd(3'd0, v); chk("R7 carry into seconds", v, 32'h6);
    wr_wait(3'd4, 32'h0);
    rd(3'd1, v1);
    ticks(3);
    rd(3'd1, v); chk("R7 halted when run clear", v, v1);

    cur_req = "R8";
    wr_wait(3'd4, 32'h8);
    wr(3'd1, 32'h1000);
    idle();
    rd(3'd1, v); chk("R8 load replaces step", v, 32'h1000);

    cur_req = "R3";
    wr(3'd2, 32'h10);
    wr(3'd3, 32'h55);
    idle();
    rd(3'd3, v); chk("R3 dropped write", v, 32'h0);
    rd(3'd2, v); chk("R3 first write landed", v, 32'h10);
    rd(3'd5, v); chk("R3 error flag", v, 32'h380);

    cur_req = "R10";
    wr_wait(3'd6, 32'h80);
    @(negedge clk);
    chk("R10 irq from error", {31'h0, irq}, 32'h1);
    cur_req = "R4";
    wr_wait(3'd5, 32'h100);
    rd(3'd5, v); chk("R4 error survives other clear", v, 32'h280);
    wr_wait(3'd5, 32'h80);
    rd(3'd5, v); chk("R4 error cleared by write", v, 32'h300);
    cur_req = "R10";
    @(negedge clk);
    chk("R10 irq released", {31'h0, irq}, 32'h0);

    cur_req = "R9";
    wr_wait(3'd4, 32'h0);
    wr_wait(3'd1, 32'h0);
    wr_wait(3'd0, 32'h20);
    wr_wait(3'd3, 32'h8);
    wr_wait(3'd2, 32'h20);
    wr_wait(3'd6, 32'h10);
    wr_wait(3'd4, 32'h8);
    ticks(12);
    rd(3'd5, v); chk("R9 alarm raised", v, 32'h310);
    chk("R10 irq from alarm", {31'h0, irq}, 32'h1);
    ticks(4);
    rd(3'd5, v); chk("R9 alarm sticky", v, 32'h310);

    wr_wait(3'd4, 32'h0);
    wr_wait(3'd1, 32'h100);
    wr_wait(3'd0, 32'h40);
    wr_wait(3'd3, 32'h104);
    wr_wait(3'd2, 32'h40);
    wr_wait(3'd4, 32'h8);
    wr(3'd5, 32'h10);
    idle();
    rd(3'd5, v); chk("R9 set beats same-cycle clear", v, 32'h310);
    rd(3'd1, v); chk("R9 count on alarm value", v, 32'h104);
    wr_wait(3'd5, 32'h10);
    rd(3'd5, v); chk("R9 later clear works", v, 32'h300);

    wr_wait(3'd4, 32'h0);
    wr_wait(3'd2, 32'hFFFF_FFFF);
    wr_wait(3'd3, 32'h5);
    wr_wait(3'd1, 32'h0);
    wr_wait(3'd0, 32'hFFFF_FFFF);
    wr_wait(3'd4, 32'h8);
    ticks(10);
    rd(3'd5, v); chk("R9 all-ones seconds disables alarm", v, 32'h300);

    repeat (4) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule